// File: doc/BRIEF.md
# Third-Order Fractional-N Divide Ratio Modulator

This block chooses the division ratio that a fractional-N synthesizer's feedback divider uses in each reference cycle. It holds three values: an integer part, a fractional numerator and a modulus. On each strobe from the divider it produces one divide value. That value is the integer part plus a noise-shaped offset, and it is clamped to the range the divider can count. The offset comes from three first-order accumulators in cascade. Each accumulator wraps at the programmed modulus, which can be any value from 1 to 2047. The carries of the three accumulators are combined through first, second and third difference terms. Over time the divide values average to the integer part plus numerator divided by modulus.

The divider asks for the next value through a valid/ready strobe input, and the value comes back on a valid/ready output. The output is held in a one-deep register. While a value is waiting and the consumer holds `div_ready` low, the register and the modulator state stay frozen and `stb_ready` is low. A new strobe is accepted in the same cycle that the waiting value is consumed, so one value can move per cycle. A configuration load is a plain pulse. It takes priority over a strobe in the same cycle, clears the accumulators and the carry history, and discards any value that has not yet been consumed. The first strobe after the load already uses the new settings.

Top module: `fracn_sdm`

## Requirements
- R1: After reset, `div_valid` is 0 and `stb_ready` is 1. The reset configuration is integer 21, numerator 0 and modulus 1.
- R2: With a numerator of 0, every divide value equals the integer part (after the clamp of R6).
- R3: Each accepted strobe adds the numerator to stage 1, and stage k+1 adds the new residue of stage k. A stage whose sum reaches the modulus sets its carry and subtracts the modulus. With carries c1, c2, c3 and their earlier values, the offset is c1 + c2 − c2[n−1] + c3 − 2·c3[n−1] + c3[n−2].
- R4: Starting from a load, the divide values of 8·M consecutive strobes sum to between S−1 and S+2, where S = 8·(integer·M + numerator), provided no value was clamped.
- R5: The offset added to the integer part always lies between −3 and +4.
- R6: Every divide value is clamped to the range 21 to 123 inclusive.
- R7: A load clears the accumulators and the carry history, and drops any value not yet consumed, so `div_valid` is 0 in the cycle after a load. The next accepted strobe uses the new values.
- R8: A loaded modulus of 0 is treated as 1. A loaded numerator that is not below the modulus is treated as modulus − 1.
- R9: While `div_valid` is 1 and `div_ready` is 0, `div_ratio` and `div_valid` hold, `stb_ready` is 0, and no strobe is accepted.
- R10: In a cycle with `cfg_load` high, `stb_ready` is 0, so a strobe that arrives with the load is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load pulse for the three settings below |
| cfg_int | input | 7 | Integer part of the divide ratio |
| cfg_num | input | 11 | Fractional numerator |
| cfg_mod | input | 11 | Fractional modulus |
| stb_valid | input | 1 | Divider requests the next ratio |
| stb_ready | output | 1 | Modulator can take a request |
| div_valid | output | 1 | A divide value is waiting |
| div_ready | input | 1 | Divider takes the waiting value |
| div_ratio | output | 7 | Divide value |

## Verification
The hardest case to reach from the ports is the one where the second and third stages carry at the same time and the residual terms stop the sum over 8·M strobes from landing exactly on its ideal value. To reach it, the stimulus uses large, nearly full numerators against moduli of 100, 300 and 2047, including the full 8·2047-strobe window. The clamp edges are reached with an integer part of 21 and a numerator just below the modulus, and with an integer part of 123. A behavioural model follows every clock under random back-pressure, and configuration loads land while strobes are pending.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int SDM_MOD_W     = 11;
  localparam int SDM_INT_W     = 7;
  localparam int SDM_ORDER     = 3;
  localparam int SDM_OFS_W     = 4;
  localparam int SDM_RATIO_MIN = 21;
  localparam int SDM_RATIO_MAX = 123;

  typedef logic signed [SDM_OFS_W-1:0] sdm_ofs_t;
endpackage

// File: rtl/sdm_cfg.sv
module sdm_cfg #(
  parameter int MOD_W   = 11,
  parameter int INT_W   = 7,
  parameter int INT_RST = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [INT_W-1:0] int_in,
  input  logic [MOD_W-1:0] num_in,
  input  logic [MOD_W-1:0] mod_in,
  output logic [INT_W-1:0] int_q,
  output logic [MOD_W-1:0] num_q,
  output logic [MOD_W-1:0] mod_q
);
  logic [MOD_W-1:0] mod_fix;
  logic [MOD_W-1:0] num_fix;

  // Sanitise the settings: a zero modulus becomes 1, and the numerator is held below the modulus
  always_comb begin
    mod_fix = (mod_in == '0) ? MOD_W'(1) : mod_in;
    num_fix = (num_in >= mod_fix) ? (mod_fix - MOD_W'(1)) : num_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q <= INT_W'(INT_RST);
      num_q <= '0;
      mod_q <= MOD_W'(1);
    end else if (load) begin
      int_q <= int_in;
      num_q <= num_fix;
      mod_q <= mod_fix;
    end
  end

  assert_num_below_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    num_q < mod_q);
  assert_mod_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_q != '0);
endmodule

// File: rtl/sdm_accum.sv
module sdm_accum #(
  parameter int MOD_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [MOD_W-1:0] inc,
  input  logic [MOD_W-1:0] modulus,
  output logic [MOD_W-1:0] resid,
  output logic             carry
);
  localparam int SUM_W = MOD_W + 1;

  logic [MOD_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, inc};
    wrapped = sum - {1'b0, modulus};
    carry   = (sum >= {1'b0, modulus});
    resid   = carry ? wrapped[MOD_W-1:0] : sum[MOD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr)   acc_q <= '0;
    else if (step)  acc_q <= resid;
  end

  // The stored residue stays below the modulus (R3)
  assert_acc_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < modulus);
  assert_acc_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/sdm_shaper.sv
module sdm_shaper
  import sdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic [2:0] carry,
  output sdm_ofs_t   offset
);
  logic c2_d;
  logic c3_d;
  logic c3_dd;
  int   sum_i;

  // First, second and third difference terms of the three carries
  always_comb begin
    sum_i  = int'(carry[0])
           + int'(carry[1]) - int'(c2_d)
           + int'(carry[2]) - 2 * int'(c3_d) + int'(c3_dd);
    offset = sdm_ofs_t'(sum_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (step) begin
      c2_d  <= carry[1];
      c3_d  <= carry[2];
      c3_dd <= c3_d;
    end
  end

  assert_ofs_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (offset >= -3 && offset <= 4));
  assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (c3_dd == $past(c3_d)));
endmodule

// File: rtl/fracn_sdm.sv
module fracn_sdm
  import sdm_pkg::*;
#(
  parameter int MOD_W     = SDM_MOD_W,
  parameter int INT_W     = SDM_INT_W,
  parameter int RATIO_MIN = SDM_RATIO_MIN,
  parameter int RATIO_MAX = SDM_RATIO_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [INT_W-1:0] cfg_int,
  input  logic [MOD_W-1:0] cfg_num,
  input  logic [MOD_W-1:0] cfg_mod,
  input  logic             stb_valid,
  output logic             stb_ready,
  output logic             div_valid,
  input  logic             div_ready,
  output logic [INT_W-1:0] div_ratio
);
  localparam int ORDER = SDM_ORDER;

  logic [INT_W-1:0]            int_q;
  logic [MOD_W-1:0]            num_q;
  logic [MOD_W-1:0]            mod_q;
  logic                        fire;
  logic [ORDER:0][MOD_W-1:0]   chain;
  logic [ORDER-1:0]            carry;
  sdm_ofs_t                    offset;
  int                          raw_i;
  logic [INT_W-1:0]            ratio_next;

  sdm_cfg #(.MOD_W(MOD_W), .INT_W(INT_W), .INT_RST(RATIO_MIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .int_in(cfg_int), .num_in(cfg_num), .mod_in(cfg_mod),
    .int_q(int_q), .num_q(num_q), .mod_q(mod_q)
  );

  // Strobe handshake: a load blocks it; a waiting value blocks it unless it leaves now
  assign stb_ready = (!div_valid || div_ready) && !cfg_load;
  assign fire      = stb_valid && stb_ready;
  assign chain[0]  = num_q;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    sdm_accum #(.MOD_W(MOD_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .step(fire),
      .inc(chain[g]), .modulus(mod_q),
      .resid(chain[g+1]), .carry(carry[g])
    );
  end

  sdm_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .clr(cfg_load), .step(fire),
    .carry(carry), .offset(offset)
  );

  always_comb begin
    raw_i = int'(int_q) + int'(offset);
    if (raw_i < RATIO_MIN)      ratio_next = INT_W'(RATIO_MIN);
    else if (raw_i > RATIO_MAX) ratio_next = INT_W'(RATIO_MAX);
    else                        ratio_next = INT_W'(raw_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_valid <= 1'b0;
      div_ratio <= INT_W'(RATIO_MIN);
    end else if (cfg_load) begin
      div_valid <= 1'b0;
    end else if (fire) begin
      div_valid <= 1'b1;
      div_ratio <= ratio_next;
    end else if (div_ready) begin
      div_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_valid && !div_ready && !cfg_load) |=> (div_valid && $stable(div_ratio)));
  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> (div_ratio >= INT_W'(RATIO_MIN) && div_ratio <= INT_W'(RATIO_MAX)));
  assert_load_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !div_valid);
  assert_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_valid && stb_ready) |=> div_valid);
  assert_last_resid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (chain[ORDER] < mod_q));
endmodule

// File: tb/fracn_sdm_bench.sv
module fracn_sdm_bench;
  localparam int MW = 11;
  localparam int IW = 7;
  localparam int RMIN = 21;
  localparam int RMAX = 123;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [IW-1:0] cfg_int = '0;
  logic [MW-1:0] cfg_num = '0;
  logic [MW-1:0] cfg_mod = '0;
  logic          stb_valid = 1'b0;
  logic          stb_ready;
  logic          div_valid;
  logic          div_ready = 1'b1;
  logic [IW-1:0] div_ratio;

  fracn_sdm u_fracn_sdm (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_int(cfg_int),
    .cfg_num(cfg_num), .cfg_mod(cfg_mod), .stb_valid(stb_valid),
    .stb_ready(stb_ready), .div_valid(div_valid), .div_ready(div_ready),
    .div_ratio(div_ratio)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit cmp_en = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: plain integers, updated on each rising edge
  int m_valid, m_ratio, a1, a2, a3, h2, h3, h33, m_int, m_num, m_mod;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_ratio = RMIN; a1 = 0; a2 = 0; a3 = 0; h2 = 0; h3 = 0; h33 = 0;
      m_int = RMIN; m_num = 0; m_mod = 1;
    end else if (cfg_load) begin
      m_int = int'(cfg_int);
      m_mod = (cfg_mod == 0) ? 1 : int'(cfg_mod);
      m_num = (int'(cfg_num) >= m_mod) ? m_mod - 1 : int'(cfg_num);
      a1 = 0; a2 = 0; a3 = 0; h2 = 0; h3 = 0; h33 = 0; m_valid = 0;
    end else if (stb_valid && (m_valid == 0 || div_ready)) begin
      int k1, k2, k3, r;
      a1 = a1 + m_num; k1 = (a1 >= m_mod); if (k1 != 0) a1 = a1 - m_mod;
      a2 = a2 + a1;    k2 = (a2 >= m_mod); if (k2 != 0) a2 = a2 - m_mod;
      a3 = a3 + a2;    k3 = (a3 >= m_mod); if (k3 != 0) a3 = a3 - m_mod;
      r = m_int + k1 + k2 - h2 + k3 - 2 * h3 + h33;
      m_ratio = (r < RMIN) ? RMIN : ((r > RMAX) ? RMAX : r);
      h33 = h3; h3 = k3; h2 = k2;
      m_valid = 1;
    end else if (div_ready) begin
      m_valid = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      chk(int'(div_valid) == m_valid, "R9 valid vs model", int'(div_valid), m_valid);
      if (m_valid != 0) chk(int'(div_ratio) == m_ratio, "R3 ratio vs model", int'(div_ratio), m_ratio);
      if (div_valid) chk(div_ratio >= RMIN && div_ratio <= RMAX, "R6 range", int'(div_ratio), RMIN);
    end
  end

  int sum_g, min_g, max_g;

  task automatic load(input int iv, input int nv, input int mv, input bit sv);
    @(posedge clk); #2;
    cfg_int = IW'(iv); cfg_num = MW'(nv); cfg_mod = MW'(mv);
    cfg_load = 1'b1; stb_valid = sv; div_ready = 1'b1;
    @(negedge clk);
    chk(stb_ready == 1'b0, "R10 load blocks strobe", int'(stb_ready), 0);
    @(posedge clk); #2;
    cfg_load = 1'b0; stb_valid = 1'b0;
    @(negedge clk);
    chk(div_valid == 1'b0, "R7 load drops value", int'(div_valid), 0);
  endtask

  task automatic run(input int n, input bit bp);
    int acc = 0;
    int cons = 0;
    sum_g = 0; min_g = 1000; max_g = -1;
    while (cons < n) begin
      @(posedge clk); #2;
      stb_valid = (acc < n) && (bp ? ($urandom_range(3) != 0) : 1'b1);
      div_ready = bp ? ($urandom_range(2) != 0) : 1'b1;
      @(negedge clk);
      if (stb_valid && stb_ready) acc++;
      if (div_valid && div_ready) begin
        cons++;
        sum_g += int'(div_ratio);
        if (int'(div_ratio) < min_g) min_g = int'(div_ratio);
        if (int'(div_ratio) > max_g) max_g = int'(div_ratio);
      end
    end
    @(posedge clk); #2;
    stb_valid = 1'b0; div_ready = 1'b1;
  endtask

  task automatic sum_window(input int iv, input int nv, input int mv, input bit bp, input string req);
    int s;
    load(iv, nv, mv, 1'b0);
    run(8 * mv, bp);
    s = 8 * (iv * mv + nv);
    chk(sum_g >= s - 1 && sum_g <= s + 2, req, sum_g, s);
  endtask

  task automatic finish_run;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int first;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(div_valid == 1'b0, "R1 valid after reset", int'(div_valid), 0);
    chk(stb_ready == 1'b1, "R1 ready after reset", int'(stb_ready), 1);
    cmp_en = 1;

    // R1 and R2: reset configuration gives the integer 21 on every strobe
    run(20, 1'b0);
    chk(sum_g == 20 * 21, "R1 default config sum", sum_g, 20 * 21);

    // R2: zero numerator under back-pressure
    load(60, 0, 100, 1'b0);
    run(100, 1'b1);
    chk(sum_g == 100 * 60, "R2 zero numerator sum", sum_g, 6000);
    chk(min_g == 60 && max_g == 60, "R2 constant ratio", min_g, 60);

    // R4 windows with different fill patterns
    sum_window(50, 37, 100, 1'b0, "R4 sum 50+37/100");
    sum_window(90, 97, 100, 1'b1, "R4 sum 90+97/100");
    sum_window(80, 1, 2047, 1'b1, "R4 sum 80+1/2047");
    sum_window(100, 2046, 2047, 1'b0, "R4 sum 100+2046/2047");

    // R6: low clamp and high clamp
    load(21, 1999, 2000, 1'b0);
    run(300, 1'b0);
    chk(min_g == RMIN, "R6 low clamp reached", min_g, RMIN);
    load(123, 5, 7, 1'b0);
    run(100, 1'b0);
    chk(max_g == RMAX, "R6 high clamp reached", max_g, RMAX);

    // R8: modulus 0 acts as 1; numerator at or above the modulus becomes modulus-1
    load(70, 5, 0, 1'b0);
    run(30, 1'b0);
    chk(sum_g == 30 * 70, "R8 zero modulus", sum_g, 2100);
    load(40, 500, 300, 1'b0);
    run(2400, 1'b0);
    chk(sum_g >= 8 * (40 * 300 + 299) - 1 && sum_g <= 8 * (40 * 300 + 299) + 2,
        "R8 numerator saturated", sum_g, 8 * (40 * 300 + 299));

    // R9: hold under back-pressure
    load(45, 3, 8, 1'b0);
    @(posedge clk); #2 stb_valid = 1'b1; div_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    first = int'(div_ratio);
    chk(div_valid == 1'b1, "R9 value waiting", int'(div_valid), 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(stb_ready == 1'b0, "R9 strobe blocked", int'(stb_ready), 0);
      chk(int'(div_ratio) == first, "R9 ratio held", int'(div_ratio), first);
    end
    @(posedge clk); #2 stb_valid = 1'b0; div_ready = 1'b1;

    // R7 and R10: load while strobes stream, then new settings from the next strobe
    @(posedge clk); #2 stb_valid = 1'b1; div_ready = 1'b1;
    repeat (5) @(posedge clk);
    load(90, 3, 4, 1'b1);
    run(32, 1'b0);
    chk(sum_g >= 8 * 363 - 1 && sum_g <= 8 * 363 + 2, "R7 new settings after load", sum_g, 8 * 363);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule